// File: doc/BRIEF.md
# Standby Mode Controller

This block moves a small processor out of normal execution into one of four low-power standby states and back again. Software requests a state by writing a one-hot command byte through a write strobe. In the same cycle the controller checks whether entry is allowed. It looks at the stop-acceptor enable, at the enabled-and-pending interrupt sources, and at the status of the high-speed and low-speed oscillators. A legal request changes the state on the next clock edge. A refused request leaves the state alone and raises a one-cycle rejection pulse.

In every state the controller drives four clock enables: CPU, peripheral, high-speed and low-speed. In a standby state, any interrupt source that is both enabled and requesting brings it back to normal execution and raises a wake pulse. A companion flag tells the core whether to service the interrupt, which it does only when the master interrupt enable was set. Otherwise the core just resumes. The command register is write-only and keeps no bits. The state itself is reported on a 3-bit output.

Top module: `standby_ctrl`

## Requirements
- R1: After reset the state output is 0 (RUN), all four clock enables are 1, and the rejection, wake and service outputs are 0.
- R2: In RUN, a write whose bits [3:0] hold exactly one 1 and that passes every check moves the state on the next edge. Bit 0 selects HALT (code 1), bit 1 selects STOP (code 2), bit 2 selects DEEP-HALT (code 3) and bit 3 selects HALT-H (code 4).
- R3: A write whose bits [3:0] are all 0 changes nothing and raises no rejection, whatever bits [7:4] hold.
- R4: A write with two or more of bits [3:0] set is refused, and the state stays RUN.
- R5: A STOP request is refused unless stop_accept_i is 1 on the write edge.
- R6: A HALT, STOP or DEEP-HALT request is refused while any source has both its irq_en_i and irq_req_i bit at 1, whether mie_i is 0 or 1. A HALT-H request is not blocked by pending sources.
- R7: When hosc_sel_i and hosc_stat_i are both 1, a request for STOP, DEEP-HALT or HALT-H is refused. When losc_sel_i and losc_stat_i are both 1, a request for DEEP-HALT is refused. HALT is not affected by either oscillator.
- R8: The clock enables follow the state. In RUN all four are 1. HALT clears only cpu_clk_en_o. HALT-H clears cpu_clk_en_o and hs_clk_en_o. DEEP-HALT clears cpu_clk_en_o and periph_clk_en_o. STOP clears all four.
- R9: In any standby state, an enabled pending source on an edge returns the state to RUN on that edge. On the same cycle wake_o pulses for one cycle and irq_service_o takes the value mie_i had on that edge. A pending source that is not enabled does not wake the controller.
- R10: Writes that arrive while the state is not RUN are ignored. They change no state and raise no rejection.
- R11: entry_rejected_o is 1 for exactly the one cycle after each refused write and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command register write strobe |
| wr_data_i | input | 8 | Command byte |
| stop_accept_i | input | 1 | Stop acceptor enabled |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| irq_req_i | input | N_IRQ | Per-source interrupt requests |
| mie_i | input | 1 | Master interrupt enable |
| hosc_sel_i | input | 1 | High-speed oscillator in use |
| hosc_stat_i | input | 1 | High-speed oscillator status bit |
| losc_sel_i | input | 1 | Low-speed oscillator in use |
| losc_stat_i | input | 1 | Low-speed oscillator status bit |
| mode_o | output | 3 | Current state code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| hs_clk_en_o | output | 1 | High-speed clock enable |
| ls_clk_en_o | output | 1 | Low-speed clock enable |
| entry_rejected_o | output | 1 | One-cycle pulse for a refused write |
| wake_o | output | 1 | One-cycle pulse on return to RUN |
| irq_service_o | output | 1 | Interrupt to be serviced on wake |

## Verification
The hardest situation to reach is a HALT-H entry made while an enabled source is already pending. The write has to be accepted, and the controller then has to leave the state again on the very next edge. The stimulus creates it by holding an enable and a request high in RUN and then writing the HALT-H bit. The same held request first serves to show that HALT is refused. The bench also drives long runs of random command bytes with a bias towards single-bit and double-bit values, while the acceptor, oscillator and interrupt inputs are toggled at random. This covers refusals and wakes that overlap in both orders.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_HALT   = 3'd1,
    MODE_STOP   = 3'd2,
    MODE_DEEP   = 3'd3,
    MODE_HALT_H = 3'd4
  } sby_mode_e;

  localparam int unsigned SEL_W     = 4;
  localparam int unsigned BIT_HALT  = 0;
  localparam int unsigned BIT_STOP  = 1;
  localparam int unsigned BIT_DEEP  = 2;
  localparam int unsigned BIT_HALTH = 3;

  typedef struct packed {
    logic cpu;
    logic periph;
    logic hs;
    logic ls;
  } clk_en_t;
endpackage

// File: rtl/sby_pending.sv
module sby_pending #(
  parameter int unsigned N_IRQ = 16
) (
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_req_i,
  output logic             pending_o
);
  logic [N_IRQ-1:0] hit;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_src
    assign hit[g] = irq_en_i[g] & irq_req_i[g];
  end

  assign pending_o = |hit;
endmodule

// File: rtl/sby_decode.sv
module sby_decode
  import standby_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              stop_accept_i,
  input  logic              pending_i,
  input  logic              hosc_sel_i,
  input  logic              hosc_stat_i,
  input  logic              losc_sel_i,
  input  logic              losc_stat_i,
  output logic              none_o,
  output logic              ok_o,
  output sby_mode_e         target_o
);
  localparam int unsigned CNT_W = $clog2(SEL_W + 1);

  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] n_set;
  logic             multi;
  logic             hosc_busy, losc_busy;
  logic             blocked;
  logic             unused_hi;

  assign sel       = wr_data_i[SEL_W-1:0];
  assign unused_hi = ^wr_data_i[CTRL_W-1:SEL_W];

  always_comb begin
    n_set = '0;
    for (int i = 0; i < SEL_W; i++) n_set = n_set + CNT_W'(sel[i]);
  end

  assign none_o    = (n_set == '0);
  assign multi     = (n_set > CNT_W'(1));
  assign hosc_busy = hosc_sel_i & hosc_stat_i;
  assign losc_busy = losc_sel_i & losc_stat_i;

  always_comb begin
    target_o = MODE_RUN;
    blocked  = 1'b0;
    if (sel[BIT_HALT]) begin
      target_o = MODE_HALT;
      blocked  = pending_i;
    end else if (sel[BIT_STOP]) begin
      target_o = MODE_STOP;
      blocked  = pending_i | ~stop_accept_i | hosc_busy;
    end else if (sel[BIT_DEEP]) begin
      target_o = MODE_DEEP;
      blocked  = pending_i | hosc_busy | losc_busy;
    end else if (sel[BIT_HALTH]) begin
      target_o = MODE_HALT_H;
      blocked  = hosc_busy;
    end
  end

  assign ok_o = ~none_o & ~multi & ~blocked;
endmodule

// File: rtl/sby_clkmap.sv
module sby_clkmap
  import standby_pkg::*;
(
  input  sby_mode_e mode_i,
  output clk_en_t   en_o
);
  always_comb begin
    en_o = '{cpu: 1'b1, periph: 1'b1, hs: 1'b1, ls: 1'b1};
    unique case (mode_i)
      MODE_HALT:   en_o.cpu = 1'b0;
      MODE_HALT_H: begin
        en_o.cpu = 1'b0;
        en_o.hs  = 1'b0;
      end
      MODE_DEEP: begin
        en_o.cpu    = 1'b0;
        en_o.periph = 1'b0;
      end
      MODE_STOP:   en_o = '0;
      default:     ;
    endcase
  end
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int unsigned N_IRQ  = 16,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              stop_accept_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic [N_IRQ-1:0]  irq_req_i,
  input  logic              mie_i,
  input  logic              hosc_sel_i,
  input  logic              hosc_stat_i,
  input  logic              losc_sel_i,
  input  logic              losc_stat_i,
  output logic [2:0]        mode_o,
  output logic              cpu_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              hs_clk_en_o,
  output logic              ls_clk_en_o,
  output logic              entry_rejected_o,
  output logic              wake_o,
  output logic              irq_service_o
);
  sby_mode_e mode_q, target;
  logic      pending, none, ok;
  logic      rej_q, wake_q, svc_q;
  clk_en_t   clk_en;

  sby_pending #(.N_IRQ(N_IRQ)) u_pending (
    .irq_en_i (irq_en_i),
    .irq_req_i(irq_req_i),
    .pending_o(pending)
  );

  sby_decode #(.CTRL_W(CTRL_W)) u_decode (
    .wr_data_i    (wr_data_i),
    .stop_accept_i(stop_accept_i),
    .pending_i    (pending),
    .hosc_sel_i   (hosc_sel_i),
    .hosc_stat_i  (hosc_stat_i),
    .losc_sel_i   (losc_sel_i),
    .losc_stat_i  (losc_stat_i),
    .none_o       (none),
    .ok_o         (ok),
    .target_o     (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      rej_q  <= 1'b0;
      wake_q <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      rej_q  <= 1'b0;
      wake_q <= 1'b0;
      svc_q  <= 1'b0;
      if (mode_q == MODE_RUN) begin
        if (wr_en_i && !none) begin
          if (ok) mode_q <= target;
          else    rej_q  <= 1'b1;
        end
      end else if (pending) begin
        mode_q <= MODE_RUN;
        wake_q <= 1'b1;
        svc_q  <= mie_i;
      end
    end
  end

  sby_clkmap u_clkmap (
    .mode_i(mode_q),
    .en_o  (clk_en)
  );

  assign mode_o           = mode_q;
  assign cpu_clk_en_o     = clk_en.cpu;
  assign periph_clk_en_o  = clk_en.periph;
  assign hs_clk_en_o      = clk_en.hs;
  assign ls_clk_en_o      = clk_en.ls;
  assign entry_rejected_o = rej_q;
  assign wake_o           = wake_q;
  assign irq_service_o    = svc_q;
endmodule

// File: rtl/sby_checker.sv
module sby_checker #(
  parameter int unsigned N_IRQ  = 16,
  parameter int unsigned CTRL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [CTRL_W-1:0] wr_data_i,
  input logic              stop_accept_i,
  input logic [N_IRQ-1:0]  irq_en_i,
  input logic [N_IRQ-1:0]  irq_req_i,
  input logic              mie_i,
  input logic [2:0]        mode_o,
  input logic              cpu_clk_en_o,
  input logic              periph_clk_en_o,
  input logic              hs_clk_en_o,
  input logic              ls_clk_en_o,
  input logic              entry_rejected_o,
  input logic              wake_o,
  input logic              irq_service_o
);
  logic pend, in_run;
  assign pend   = |(irq_en_i & irq_req_i);
  assign in_run = (mode_o == 3'd0);

  a_r8_run_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_run |-> (cpu_clk_en_o && periph_clk_en_o && hs_clk_en_o && ls_clk_en_o));

  a_r8_stop_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2) |-> !(cpu_clk_en_o || periph_clk_en_o || hs_clk_en_o || ls_clk_en_o));

  a_r3_zero_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_run && wr_data_i[3:0] == 4'd0) |=> (in_run && !entry_rejected_o));

  a_r4_multi_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_run && $countones(wr_data_i[3:0]) > 1) |=> (in_run && entry_rejected_o));

  a_r5_stop_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_run && wr_data_i[3:0] == 4'b0010 && !stop_accept_i) |=> (in_run && entry_rejected_o));

  a_r6_pending_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_run && pend &&
     (wr_data_i[3:0] == 4'b0001 || wr_data_i[3:0] == 4'b0010 || wr_data_i[3:0] == 4'b0100))
    |=> (in_run && entry_rejected_o));

  a_r9_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_run && pend) |=> (in_run && wake_o && irq_service_o == $past(mie_i)));

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_run && !pend) |=> ($stable(mode_o) && !entry_rejected_o && !wake_o));

  a_r11_reject_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_rejected_o |-> in_run);
endmodule

bind standby_ctrl sby_checker #(.N_IRQ(N_IRQ), .CTRL_W(CTRL_W)) u_sby_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .stop_accept_i   (stop_accept_i),
  .irq_en_i        (irq_en_i),
  .irq_req_i       (irq_req_i),
  .mie_i           (mie_i),
  .mode_o          (mode_o),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .hs_clk_en_o     (hs_clk_en_o),
  .ls_clk_en_o     (ls_clk_en_o),
  .entry_rejected_o(entry_rejected_o),
  .wake_o          (wake_o),
  .irq_service_o   (irq_service_o)
);

// File: tb/tb_standby_ctrl.sv
module tb_standby_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ      = 16;
  localparam int WATCHDOG   = 100000;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [7:0]       wr_data_i = '0;
  logic             stop_accept_i = 1'b0;
  logic [N_IRQ-1:0] irq_en_i = '0;
  logic [N_IRQ-1:0] irq_req_i = '0;
  logic             mie_i = 1'b0;
  logic             hosc_sel_i = 1'b0, hosc_stat_i = 1'b0;
  logic             losc_sel_i = 1'b0, losc_stat_i = 1'b0;
  logic [2:0]       mode_o;
  logic             cpu_clk_en_o, periph_clk_en_o, hs_clk_en_o, ls_clk_en_o;
  logic             entry_rejected_o, wake_o, irq_service_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctrl #(.N_IRQ(N_IRQ)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .stop_accept_i(stop_accept_i), .irq_en_i(irq_en_i), .irq_req_i(irq_req_i),
    .mie_i(mie_i), .hosc_sel_i(hosc_sel_i), .hosc_stat_i(hosc_stat_i),
    .losc_sel_i(losc_sel_i), .losc_stat_i(losc_stat_i), .mode_o(mode_o),
    .cpu_clk_en_o(cpu_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
    .hs_clk_en_o(hs_clk_en_o), .ls_clk_en_o(ls_clk_en_o),
    .entry_rejected_o(entry_rejected_o), .wake_o(wake_o), .irq_service_o(irq_service_o)
  );

  // behavioural reference
  int m_mode = 0;
  bit m_rej = 0, m_wake = 0, m_svc = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode <= 0; m_rej <= 0; m_wake <= 0; m_svc <= 0;
    end else begin
      bit pend, refuse;
      int nb, tgt;
      pend = (irq_en_i & irq_req_i) != 0;
      m_rej <= 0; m_wake <= 0; m_svc <= 0;
      if (m_mode != 0) begin
        if (pend) begin
          m_mode <= 0; m_wake <= 1; m_svc <= mie_i;
        end
      end else if (wr_en_i) begin
        nb = $countones(wr_data_i[3:0]);
        if (nb > 1) m_rej <= 1;
        else if (nb == 1) begin
          refuse = 0;
          tgt = 0;
          case (wr_data_i[3:0])
            4'b0001: begin tgt = 1; refuse = pend; end
            4'b0010: begin tgt = 2; refuse = pend || !stop_accept_i || (hosc_sel_i && hosc_stat_i); end
            4'b0100: begin tgt = 3; refuse = pend || (hosc_sel_i && hosc_stat_i) || (losc_sel_i && losc_stat_i); end
            default: begin tgt = 4; refuse = hosc_sel_i && hosc_stat_i; end
          endcase
          if (refuse) m_rej <= 1;
          else m_mode <= tgt;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compared every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(mode_o == 3'(m_mode), "R2 state vs model", mode_o, m_mode);
      chk(cpu_clk_en_o == (m_mode == 0), "R8 cpu clock", cpu_clk_en_o, m_mode == 0);
      chk(hs_clk_en_o == !(m_mode == 2 || m_mode == 4), "R8 hs clock", hs_clk_en_o, !(m_mode == 2 || m_mode == 4));
      chk(periph_clk_en_o == !(m_mode == 2 || m_mode == 3), "R8 periph clock", periph_clk_en_o, !(m_mode == 2 || m_mode == 3));
      chk(ls_clk_en_o == (m_mode != 2), "R8 ls clock", ls_clk_en_o, m_mode != 2);
      chk(entry_rejected_o == m_rej, "R11 reject pulse", entry_rejected_o, m_rej);
      chk(wake_o == m_wake, "R9 wake pulse", wake_o, m_wake);
      chk(irq_service_o == m_svc, "R9 service flag", irq_service_o, m_svc);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic expect_st(input string tag, input int md, input bit rej);
    chk(mode_o == 3'(md), tag, mode_o, md);
    chk(entry_rejected_o == rej, tag, entry_rejected_o, rej);
  endtask

  task automatic wake_now(input bit mie);
    mie_i = mie; irq_en_i = 16'h0010; irq_req_i = 16'h0010;
    idle();
    chk(mode_o == 0 && wake_o == 1, "R9 wake to RUN", mode_o, 0);
    chk(irq_service_o == mie, "R9 service follows master enable", irq_service_o, mie);
    irq_en_i = '0; irq_req_i = '0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle();
    // R1
    chk(mode_o == 0 && cpu_clk_en_o && periph_clk_en_o && hs_clk_en_o && ls_clk_en_o,
        "R1 reset state", mode_o, 0);
    chk(!entry_rejected_o && !wake_o && !irq_service_o, "R1 reset pulses", entry_rejected_o, 0);

    hosc_sel_i = 1; losc_sel_i = 1; stop_accept_i = 1; mie_i = 1;

    wr(8'h01); expect_st("R2 enter HALT", 1, 0);
    chk(!cpu_clk_en_o && hs_clk_en_o, "R8 HALT clocks", cpu_clk_en_o, 0);
    wr(8'h02); expect_st("R10 write ignored in HALT", 1, 0);
    wake_now(1'b1);

    stop_accept_i = 0;
    wr(8'h02); expect_st("R5 STOP without acceptor", 0, 1);
    idle(); chk(!entry_rejected_o, "R11 pulse lasts one cycle", entry_rejected_o, 0);
    stop_accept_i = 1;
    wr(8'h02); expect_st("R2 enter STOP", 2, 0);
    chk(!ls_clk_en_o && !periph_clk_en_o, "R8 STOP clocks", ls_clk_en_o, 0);
    wake_now(1'b0);

    wr(8'h04); expect_st("R2 enter DEEP-HALT", 3, 0);
    chk(!periph_clk_en_o && hs_clk_en_o, "R8 DEEP-HALT clocks", periph_clk_en_o, 0);
    irq_en_i = 16'h0000; irq_req_i = 16'hFFFF; idle();
    chk(mode_o == 3, "R9 disabled request does not wake", mode_o, 3);
    wake_now(1'b1);

    wr(8'h08); expect_st("R2 enter HALT-H", 4, 0);
    chk(!hs_clk_en_o && !cpu_clk_en_o, "R8 HALT-H clocks", hs_clk_en_o, 0);
    wake_now(1'b1);

    wr(8'hF0); expect_st("R3 zero mode bits", 0, 0);
    wr(8'h03); expect_st("R4 two bits set", 0, 1);
    wr(8'h0C); expect_st("R4 two bits set high", 0, 1);

    mie_i = 0; irq_en_i = 16'h8000; irq_req_i = 16'h8000;
    wr(8'h01); expect_st("R6 HALT blocked by pending", 0, 1);
    wr(8'h04); expect_st("R6 DEEP-HALT blocked by pending", 0, 1);
    wr(8'h08); expect_st("R6 HALT-H not blocked", 4, 0);
    idle();
    chk(mode_o == 0 && wake_o && !irq_service_o, "R9 immediate wake from HALT-H", mode_o, 0);
    irq_en_i = '0;
    wr(8'h01); expect_st("R6 unenabled request does not block", 1, 0);
    mie_i = 1; irq_en_i = 16'h8000; idle(); irq_en_i = '0; irq_req_i = '0;

    hosc_stat_i = 1;
    wr(8'h02); expect_st("R7 STOP blocked by hs osc", 0, 1);
    wr(8'h08); expect_st("R7 HALT-H blocked by hs osc", 0, 1);
    wr(8'h01); expect_st("R7 HALT ignores oscillators", 1, 0);
    wake_now(1'b1);
    hosc_sel_i = 0;
    wr(8'h04); expect_st("R7 DEEP-HALT allowed when hs osc unused", 3, 0);
    wake_now(1'b1);
    losc_stat_i = 1;
    wr(8'h04); expect_st("R7 DEEP-HALT blocked by ls osc", 0, 1);
    wr(8'h02); expect_st("R7 STOP ignores ls osc", 2, 0);
    wake_now(1'b1);

    // random traffic, model compared each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en_i = ($urandom_range(0, 2) != 0);
      case ($urandom_range(0, 3))
        0: wr_data_i = 8'(1 << $urandom_range(0, 3)) | 8'($urandom_range(0, 15) << 4);
        1: wr_data_i = 8'(3 << $urandom_range(0, 2));
        2: wr_data_i = 8'($urandom_range(0, 255));
        default: wr_data_i = 8'(1 << $urandom_range(0, 3));
      endcase
      stop_accept_i = ($urandom_range(0, 3) != 0);
      irq_en_i  = N_IRQ'($urandom_range(0, 3) == 0 ? (1 << $urandom_range(0, N_IRQ-1)) : 0);
      irq_req_i = N_IRQ'($urandom_range(0, 1) == 0 ? (1 << $urandom_range(0, N_IRQ-1)) : 0) | irq_en_i & N_IRQ'($urandom_range(0, 1));
      mie_i       = 1'($urandom_range(0, 1));
      hosc_sel_i  = 1'($urandom_range(0, 1));
      hosc_stat_i = ($urandom_range(0, 3) == 0);
      losc_sel_i  = 1'($urandom_range(0, 1));
      losc_stat_i = ($urandom_range(0, 3) == 0);
    end
    wr_en_i = 0;
    idle(); idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule